// File: doc/BRIEF.md
# Queued Interrupt Arbiter for a Multi-Drive Disk Controller

This block sits between the command logic of an eight-drive disk controller and the processor's single interrupt request line. Two kinds of event ask for attention: the controller finishing a transfer-type command, and any drive finishing a seek on its own. Several seeks can finish while no acknowledge has arrived yet. The block keeps one pending bit per source, so none of them is lost. It raises one request line. On each acknowledge it hands back a fixed vector and reports which drive caused the interrupt.

The command logic supplies the events: pulses for DONE being set and cleared, a per-drive seek-finished vector, and writes to the control register that carry the new interrupt-enable value. The block owns the DONE, interrupt-enable and search-complete flags that these events affect. The drive number it reports on each acknowledge is the 3-bit field that software finds in bits 15:13 of the drive status register.

Top module: `irq_queue_arbiter`

## Requirements
- R1: After synchronous reset: the request line is low, DONE is 1, interrupt-enable is 0, search-complete is 0, the vector output is 0, the drive ID output is 0, and the queue is empty.
- R2: The queue has NUM_DRIVES+1 bits. Bit 0 is the controller source and bit n+1 is the seek source of drive n. An acknowledge services and clears the lowest-numbered set bit. From the next clock the vector output holds IRQ_VECTOR (default 8'hA0).
- R3: When the controller bit is serviced, the drive ID output becomes the drive of the most recent DONE-clear whose seek flag was 0. When the bit of drive n is serviced, the drive ID output becomes n. Both values appear on the clock after the acknowledge.
- R4: An acknowledge while the queue is empty sets the vector output to 0 on the next clock, leaves the drive ID output unchanged, and leaves the request line low.
- R5: In the cycle after an acknowledge, the request line is low. If bits are still pending, it goes high again one cycle later, provided nothing in between emptied the queue or dropped the request.
- R6: A control-register write with interrupt-enable 0 empties the queue and drops the request line. A later acknowledge then returns vector 0.
- R7: A control-register write with interrupt-enable 1, made while interrupt-enable was 0 and DONE was 1, queues the controller bit and raises the request line.
- R8: A seek completion sets search-complete. If interrupt-enable is 1, it queues that drive's bit, and it raises the request line only when DONE is 1. If interrupt-enable is 0, it empties the queue and drops the request line.
- R9: A DONE-set pulse sets DONE. If interrupt-enable is 1, it queues the controller bit and raises the request line. Otherwise it empties the queue and drops the request line.
- R10: A DONE-clear pulse clears DONE and search-complete. It removes only the controller bit from the queue and drops the request line. Pending seek bits survive and are delivered after a later DONE-set.
- R11: Events in the same cycle take effect in a fixed order: acknowledge first, then the control-register write, then DONE-clear, then DONE-set, then seek completions. Each later step sees the flags left by the earlier steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_wr_i | input | 1 | Control-register write strobe |
| csr_ie_i | input | 1 | Interrupt-enable value carried by the write |
| done_set_i | input | 1 | Pulse: the controller sets DONE |
| done_clr_i | input | 1 | Pulse: a command starts and DONE clears |
| op_drive_i | input | 3 | Drive addressed by the command that clears DONE |
| op_seek_i | input | 1 | The command that clears DONE is a seek |
| seek_done_i | input | 8 | Per-drive seek-finished pulses |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request line |
| vec_o | output | 8 | Vector returned by the latest acknowledge |
| drive_id_o | output | 3 | Drive ID field, bits 15:13 of the drive status register |
| done_o | output | 1 | DONE flag |
| ie_o | output | 1 | Interrupt-enable flag |
| search_done_o | output | 1 | Search-complete flag |

## Verification
The bench targets several corner cases.

- **Priority.** A controller bit and several seek bits are pending together. A design that scanned the queue from the wrong end would deliver a drive's ID before the controller's.
- **Seeks while DONE is clear.** Seeks finish while DONE is clear. A design that raised the request on those seeks would interrupt in the middle of a transfer. A design that discarded those bits would never report those drives.
- **Acknowledge on an empty queue.** A design that repeated the old vector would break passive release.
- **Disabling interrupts.** A design that only dropped the request line would later deliver stale bits.
- **Same-cycle events.** Random cycles put several events in one cycle, which exposes any departure from the fixed order.

// File: rtl/irq_queue_pkg.sv
package irq_queue_pkg;
    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/lowest_set_picker.sv
module lowest_set_picker #(
    parameter int W = 9,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_queue_arbiter.sv
module irq_queue_arbiter
    import irq_queue_pkg::*;
#(
    parameter int   NUM_DRIVES = 8,
    parameter vec_t IRQ_VECTOR = 8'hA0,
    localparam int  QW  = NUM_DRIVES + 1,
    localparam int  IDW = $clog2(NUM_DRIVES),
    localparam int  PW  = $clog2(QW)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  csr_wr_i,
    input  logic                  csr_ie_i,
    input  logic                  done_set_i,
    input  logic                  done_clr_i,
    input  logic [IDW-1:0]        op_drive_i,
    input  logic                  op_seek_i,
    input  logic [NUM_DRIVES-1:0] seek_done_i,
    input  logic                  ack_i,
    output logic                  irq_o,
    output vec_t                  vec_o,
    output logic [IDW-1:0]        drive_id_o,
    output logic                  done_o,
    output logic                  ie_o,
    output logic                  search_done_o
);
    typedef struct packed {
        logic [QW-1:0]  queue;
        logic           irq;
        logic           rearm;
        logic           done;
        logic           ie;
        logic           scp;
        logic [IDW-1:0] last;
        logic [IDW-1:0] id;
        vec_t           vec;
    } arb_state_t;

    arb_state_t st_q, st_d;
    logic          pick_found;
    logic [PW-1:0] pick_idx;

    lowest_set_picker #(.W(QW)) u_pick (
        .req_i   (st_q.queue),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = st_q.irq | st_q.rearm;
        st_d.rearm = 1'b0;

        // Acknowledge works on the queue as it stood at the start of the cycle.
        if (ack_i) begin
            st_d.irq = 1'b0;
            if (pick_found) begin
                st_d.queue[pick_idx] = 1'b0;
                st_d.vec             = IRQ_VECTOR;
                st_d.id              = (pick_idx == '0) ? st_q.last
                                                        : IDW'(pick_idx - 1'b1);
            end else begin
                st_d.vec = '0;
            end
        end

        if (csr_wr_i) begin
            if (!csr_ie_i) begin
                st_d.queue = '0;
                st_d.irq   = 1'b0;
            end else if (st_q.done && !st_q.ie) begin
                st_d.queue[0] = 1'b1;
                st_d.irq      = 1'b1;
            end
            st_d.ie = csr_ie_i;
        end

        if (done_clr_i) begin
            st_d.done     = 1'b0;
            st_d.scp      = 1'b0;
            st_d.queue[0] = 1'b0;
            st_d.irq      = 1'b0;
            if (!op_seek_i) st_d.last = op_drive_i;
        end

        if (done_set_i) begin
            st_d.done = 1'b1;
            if (st_d.ie) begin
                st_d.queue[0] = 1'b1;
                st_d.irq      = 1'b1;
            end else begin
                st_d.queue = '0;
                st_d.irq   = 1'b0;
            end
        end

        if (|seek_done_i) begin
            st_d.scp = 1'b1;
            if (st_d.ie) begin
                st_d.queue[QW-1:1] = st_d.queue[QW-1:1] | seek_done_i;
                if (st_d.done) st_d.irq = 1'b1;
            end else begin
                st_d.queue = '0;
                st_d.irq   = 1'b0;
            end
        end

        st_d.rearm = ack_i && (st_d.queue != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o         = st_q.irq;
    assign vec_o         = st_q.vec;
    assign drive_id_o    = st_q.id;
    assign done_o        = st_q.done;
    assign ie_o          = st_q.ie;
    assign search_done_o = st_q.scp;

    // R2: a raised request always has a pending source behind it.
    p_req_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (st_q.queue != '0));

    // R4: an acknowledge on an empty queue yields vector 0.
    p_empty_ack_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_i && st_q.queue == '0) |=> (vec_o == '0));

    // R5: the request is low in the cycle after an acknowledge when no raising event coincides.
    p_ack_drops_req_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !csr_wr_i && !done_set_i && seek_done_i == '0) |=> !irq_o);

    // R6: while interrupts are disabled, nothing stays queued.
    p_disabled_empty_r6: assert property (@(posedge clk) disable iff (rst)
        !ie_o |-> (st_q.queue == '0));

    // R10: a DONE-clear leaves no controller bit behind unless DONE is set again.
    p_clear_ctrl_bit_r10: assert property (@(posedge clk) disable iff (rst)
        (done_clr_i && !done_set_i) |=> (!st_q.queue[0] && !done_o));
endmodule

// File: tb/tb_irq_queue_arbiter.sv
module tb_irq_queue_arbiter;
    localparam int ND = 8;
    localparam logic [7:0] VEC = 8'hA0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csr_wr = 0, csr_ie = 0, dset = 0, dclr = 0, opseek = 0, ack = 0;
    logic [2:0] opdrv = '0;
    logic [ND-1:0] seek = '0;
    logic irq, done, ie, scp;
    logic [7:0] vec;
    logic [2:0] id;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    logic [ND:0] m_q;
    logic m_irq, m_rearm, m_done, m_ie, m_scp;
    logic [2:0] m_last, m_id;
    logic [7:0] m_vec;

    always #4 clk = ~clk;

    irq_queue_arbiter dut (
        .clk(clk), .rst(rst), .csr_wr_i(csr_wr), .csr_ie_i(csr_ie),
        .done_set_i(dset), .done_clr_i(dclr), .op_drive_i(opdrv),
        .op_seek_i(opseek), .seek_done_i(seek), .ack_i(ack),
        .irq_o(irq), .vec_o(vec), .drive_id_o(id), .done_o(done),
        .ie_o(ie), .search_done_o(scp)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic m_reset();
        m_q = '0; m_irq = 0; m_rearm = 0; m_done = 1; m_ie = 0; m_scp = 0;
        m_last = '0; m_id = '0; m_vec = '0;
    endtask

    // Reference per R2..R11, applied in the order fixed by R11.
    task automatic m_step();
        logic [ND:0] nq;
        logic nirq;
        logic nrearm;
        nq = m_q;
        nirq = m_irq | m_rearm;
        nrearm = 0;
        if (ack) begin
            int low;
            low = -1;
            for (int i = 0; i <= ND; i++) if (low < 0 && m_q[i]) low = i;
            nirq = 0;
            if (low < 0) m_vec = 8'h00;
            else begin
                nq[low] = 0;
                m_vec = VEC;
                m_id = (low == 0) ? m_last : 3'(low - 1);
            end
        end
        if (csr_wr) begin
            if (!csr_ie) begin nq = '0; nirq = 0; end
            else if (m_done && !m_ie) begin nq[0] = 1; nirq = 1; end
            m_ie = csr_ie;
        end
        if (dclr) begin
            m_done = 0; m_scp = 0; nq[0] = 0; nirq = 0;
            if (!opseek) m_last = opdrv;
        end
        if (dset) begin
            m_done = 1;
            if (m_ie) begin nq[0] = 1; nirq = 1; end
            else begin nq = '0; nirq = 0; end
        end
        if (seek != '0) begin
            m_scp = 1;
            if (m_ie) begin
                nq[ND:1] = nq[ND:1] | seek;
                if (m_done) nirq = 1;
            end else begin nq = '0; nirq = 0; end
        end
        nrearm = ack && (nq != '0);
        m_q = nq; m_irq = nirq; m_rearm = nrearm;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " irq"}, irq, m_irq);
        chk({tag, " vec"}, vec, m_vec);
        chk({tag, " id"}, id, m_id);
        chk({tag, " done"}, done, m_done);
        chk({tag, " ie"}, ie, m_ie);
        chk({tag, " scp"}, scp, m_scp);
    endtask

    task automatic tick(input string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
        csr_wr = 0; csr_ie = 0; dset = 0; dclr = 0; opseek = 0; ack = 0;
        opdrv = '0; seek = '0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        finish_up();
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 done", done, 1);
        chk("R1 ie", ie, 0);
        chk("R1 scp", scp, 0);
        chk("R1 vec", vec, 0);
        chk("R1 id", id, 0);

        // R7: enable while DONE=1 queues the controller bit
        csr_wr = 1; csr_ie = 1; tick("R7 enable");
        chk("R7 irq raised", irq, 1);
        ack = 1; tick("R2 ack ctrl");
        chk("R2 vector", vec, VEC);
        chk("R3 ctrl id after reset", id, 0);
        chk("R5 irq low after ack", irq, 0);

        // R10/R8: transfer on drive 5, seeks finish meanwhile
        dclr = 1; opdrv = 3'd5; tick("R10 clear");
        chk("R10 done low", done, 0);
        seek = 8'b0100_0100; tick("R8 seek while busy");
        chk("R8 no req without done", irq, 0);
        chk("R8 scp set", scp, 1);
        dset = 1; tick("R9 set done");
        chk("R9 irq", irq, 1);
        ack = 1; tick("R2 ctrl first");
        chk("R3 ctrl id is last drive", id, 5);
        chk("R5 gap cycle", irq, 0);
        tick("R5 rearm");
        chk("R5 reasserted", irq, 1);
        ack = 1; tick("R3 drive 2");
        chk("R3 id 2", id, 2);
        tick("R5 idle");
        ack = 1; tick("R3 drive 6");
        chk("R3 id 6", id, 6);
        tick("R5 idle2");
        chk("R5 empty stays low", irq, 0);
        ack = 1; tick("R4 empty ack");
        chk("R4 vec zero", vec, 0);
        chk("R4 id kept", id, 6);

        // R6: disable empties
        seek = 8'b0000_1001; tick("R8 seek with done");
        chk("R8 raise", irq, 1);
        csr_wr = 1; csr_ie = 0; tick("R6 disable");
        chk("R6 irq dropped", irq, 0);
        ack = 1; tick("R6 ack after disable");
        chk("R6 vec zero", vec, 0);

        // R8: seek with ie off, then re-enable: only controller bit
        seek = 8'b1000_0000; tick("R8 seek disabled");
        csr_wr = 1; csr_ie = 1; tick("R8 reenable");
        ack = 1; tick("R8 ack ctrl");
        chk("R8 ctrl only vec", vec, VEC);
        tick("R8 idle");
        ack = 1; tick("R8 nothing left");
        chk("R8 queue emptied", vec, 0);

        // R11: clear and set in the same cycle, seek flag ignored for last drive
        dclr = 1; dset = 1; opdrv = 3'd3; opseek = 1; tick("R11 clr+set");
        chk("R11 done", done, 1);
        chk("R11 irq", irq, 1);
        ack = 1; tick("R11 ack");
        chk("R3 seek cmd keeps last", id, 5);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            csr_wr = ($urandom % 20) == 0;
            csr_ie = ($urandom % 4) != 0;
            dset   = ($urandom % 8) == 0;
            dclr   = ($urandom % 10) == 0;
            opdrv  = 3'($urandom);
            opseek = $urandom % 2;
            seek   = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
            ack    = irq ? (($urandom % 3) == 0) : (($urandom % 30) == 0);
            tick("R11 random");
        end
        finish_up();
    end
endmodule